// File: doc/BRIEF.md
# Smart Card Contact Activation Sequencer

This block drives the contacts of a single smart card slot: the card supply enable together with its voltage class, the I/O line enable, the card clock enable and the card reset line. A power-up request brings the contacts up one at a time. Supply comes first, then I/O, then clock, and reset is released last, with a timed wait after each step. A power-off request, a supply fault or a confirmed card removal takes the contacts down in the reverse order.

A power-up request made while the card is already running does not cycle the supply. Instead it pulls reset low for the hold time and then releases it again, which is a warm reset. Card presence is debounced. Each confirmed insertion or removal produces an unsolicited event with the slot number in the high nibble of the parameter byte. Events also report a missing card and a fault-driven deactivation.

Timing is counted in cycles of `clk`. `STEP_CYC` sets the wait after each contact step. `RST_HOLD` sets how long reset is held low, with a default of 400. `DEB_CYC` sets the debounce length.

Top module: `card_contact_seq`

## Requirements
- R1: A cold activation shows, on {vcc_en,io_en,clk_en,rst_out}, the pattern 1000 for STEP_CYC cycles, then 1100 for STEP_CYC cycles, then 1110 for RST_HOLD cycles, then 1111 with `active` high. The first of these cycles follows the clock edge that samples the request.
- R2: `vsel` codes are 00 = 5 V, 01 = 3 V and 10 = 1.8 V. The code is captured into `vcc_cls` when a cold activation is accepted, and it stays unchanged while the supply is on, including across a warm reset. A power-up request with code 11 is ignored.
- R3: A power-up request while active gives 1110 for RST_HOLD cycles and then 1111. The supply is never dropped.
- R4: A power-off request while active gives 1110, then 1100, then 1000, each for STEP_CYC cycles, and then 0000. The whole deactivation takes 3*STEP_CYC cycles.
- R5: `fault` high in any powered state outside deactivation starts deactivation at the step that removes the highest contact currently on. In the same cycle it raises a one-cycle event with code 0x40.
- R6: If `vcc_ok` is low at the end of the supply step, or at any later point before deactivation, the result is the same as a fault. I/O and clock are never enabled.
- R7: A power-up request (code other than 11) while off and with no debounced card gives event code 0x82, and the contacts stay off.
- R8: A presence change is accepted only after `card_in` has held the new level for DEB_CYC consecutive clock edges. The event follows one cycle later: 0xC0 for insertion and 0xA0 for removal. Every event carries `evt_param` = {SLOT, 4'h0}.
- R9: A confirmed removal while powered starts deactivation without a 0x40 event.
- R10: Power-up and power-off requests are ignored while `busy` is high. A power-off request while off is ignored.
- R11: After reset, all contact outputs, `active`, `busy` and `evt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_req | input | 1 | Cold activation, or warm reset when active |
| pwr_off_req | input | 1 | Deactivation request |
| vsel | input | 2 | Supply class select |
| card_in | input | 1 | Raw card presence |
| vcc_ok | input | 1 | Card supply within range |
| fault | input | 1 | Supply short or overcurrent |
| vcc_en | output | 1 | Card supply enable |
| vcc_cls | output | 2 | Supply class in use |
| io_en | output | 1 | I/O line enable |
| clk_en | output | 1 | Card clock enable |
| rst_out | output | 1 | Card reset line, high = released |
| active | output | 1 | Card running |
| busy | output | 1 | Sequence in progress |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 8 | Event code |
| evt_param | output | 8 | Event parameter, slot in high nibble |

## Verification
The contact outputs are decoded directly from the sequencer state. A wrong state or a miscounted step therefore shows on the pins in the very cycle it happens. The bench compares every cycle of each phase against the expected four-bit contact pattern, so an order or duration error is caught at once. Debounce and event faults show up as an event that arrives in the wrong cycle, carries the wrong code, or never arrives, and the bench checks each of these to the exact cycle.

// File: rtl/card_contact_seq.sv
module card_contact_seq #(
  parameter int          STEP_CYC = 8,
  parameter int          RST_HOLD = 400,
  parameter int          DEB_CYC  = 16,
  parameter logic [3:0]  SLOT     = 4'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_up_req,
  input  logic       pwr_off_req,
  input  logic [1:0] vsel,
  input  logic       card_in,
  input  logic       vcc_ok,
  input  logic       fault,
  output logic       vcc_en,
  output logic [1:0] vcc_cls,
  output logic       io_en,
  output logic       clk_en,
  output logic       rst_out,
  output logic       active,
  output logic       busy,
  output logic       evt_valid,
  output logic [7:0] evt_code,
  output logic [7:0] evt_param
);
  localparam int LONG = (RST_HOLD > STEP_CYC) ? RST_HOLD : STEP_CYC;
  localparam int CW   = $clog2(LONG) + 1;
  localparam int DW   = $clog2(DEB_CYC) + 1;
  localparam logic [7:0] EV_INS = 8'hC0, EV_EXT = 8'hA0, EV_DEACT = 8'h40, EV_ABSENT = 8'h82;

  typedef enum logic [3:0] {S_OFF, S_A_VCC, S_A_IO, S_A_CLK, S_ON, S_WARM,
                            S_D_RST, S_D_CLK, S_D_IO} st_t;
  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dcnt;
  logic pres, pres_flip, pres_pend, lost, trip, seq_ev, last_step, last_hold;
  logic [7:0] seq_code;

  assign pres_flip = (card_in != pres) && (dcnt == DW'(DEB_CYC - 1));
  assign lost      = pres_flip && pres;
  assign trip      = fault || !vcc_ok;
  assign last_step = cnt == CW'(STEP_CYC - 1);
  assign last_hold = cnt == CW'(RST_HOLD - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pres <= 1'b0;
      dcnt <= '0;
    end else if (card_in == pres || pres_flip) begin
      dcnt <= '0;
      if (pres_flip) pres <= card_in;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  always_comb begin
    st_nx    = st;
    seq_ev   = 1'b0;
    seq_code = EV_DEACT;
    case (st)
      S_OFF:
        if (pwr_up_req && vsel != 2'b11) begin
          if (pres) st_nx = S_A_VCC;
          else begin seq_ev = 1'b1; seq_code = EV_ABSENT; end
        end
      S_A_VCC:
        if (fault || (last_step && !vcc_ok)) begin st_nx = S_D_IO; seq_ev = 1'b1; end
        else if (lost)                       st_nx = S_D_IO;
        else if (last_step)                  st_nx = S_A_IO;
      S_A_IO:
        if (trip)           begin st_nx = S_D_CLK; seq_ev = 1'b1; end
        else if (lost)      st_nx = S_D_CLK;
        else if (last_step) st_nx = S_A_CLK;
      S_A_CLK, S_WARM:
        if (trip)           begin st_nx = S_D_RST; seq_ev = 1'b1; end
        else if (lost)      st_nx = S_D_RST;
        else if (last_hold) st_nx = S_ON;
      S_ON:
        if (trip)             begin st_nx = S_D_RST; seq_ev = 1'b1; end
        else if (lost)        st_nx = S_D_RST;
        else if (pwr_up_req)  st_nx = S_WARM;
        else if (pwr_off_req) st_nx = S_D_RST;
      S_D_RST: if (last_step) st_nx = S_D_CLK;
      S_D_CLK: if (last_step) st_nx = S_D_IO;
      S_D_IO:  if (last_step) st_nx = S_OFF;
      default: st_nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      vcc_cls <= 2'b00;
    end else begin
      st  <= st_nx;
      cnt <= (st_nx != st || st == S_OFF || st == S_ON) ? '0 : cnt + 1'b1;
      if (st == S_OFF && st_nx == S_A_VCC) vcc_cls <= vsel;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_code  <= 8'h00;
      evt_param <= 8'h00;
      pres_pend <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      if (seq_ev) begin
        evt_valid <= 1'b1;
        evt_code  <= seq_code;
        evt_param <= {SLOT, 4'h0};
      end else if (pres_pend) begin
        evt_valid <= 1'b1;
        evt_code  <= pres ? EV_INS : EV_EXT;
        evt_param <= {SLOT, 4'h0};
        pres_pend <= 1'b0;
      end
      if (pres_flip) pres_pend <= 1'b1;
    end

  assign vcc_en  = st != S_OFF;
  assign io_en   = st inside {S_A_IO, S_A_CLK, S_ON, S_WARM, S_D_RST, S_D_CLK};
  assign clk_en  = st inside {S_A_CLK, S_ON, S_WARM, S_D_RST};
  assign rst_out = st == S_ON;
  assign active  = st == S_ON;
  assign busy    = st != S_OFF && st != S_ON;

  p_io_before_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(io_en));
  p_clk_before_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(clk_en));
  p_cls_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_en && $past(vcc_en)) |-> $stable(vcc_cls));
  p_warm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pwr_up_req && !trip && !lost) |=> (!rst_out && clk_en && vcc_en));
  p_rst_before_clkoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> $past(!rst_out));
  p_io_before_vccoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> $past(!io_en));
  p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fault) |=> (!rst_out && evt_valid && evt_code == EV_DEACT));
  p_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_en && pwr_up_req && vsel != 2'b11 && !pres) |=> (evt_valid && evt_code == EV_ABSENT));
  p_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_param == {SLOT, 4'h0});
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_A_CLK && pwr_off_req && !trip && !lost && !last_hold) |=> (clk_en && !rst_out && vcc_en));
endmodule

// File: tb/card_contact_seq_bench.sv
`timescale 1ns/1ps
module card_contact_seq_bench;
  localparam int STEP = 8, HOLD = 400, DEB = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_up_req = 0, pwr_off_req = 0, card_in = 0, vcc_ok = 1, fault = 0;
  logic [1:0] vsel = 2'b00;
  logic vcc_en, io_en, clk_en, rst_out, active, busy, evt_valid;
  logic [1:0] vcc_cls;
  logic [7:0] evt_code, evt_param;
  int total = 0, fails = 0;
  logic [3:0] pins;

  always #2.5 clk = ~clk;
  assign pins = {vcc_en, io_en, clk_en, rst_out};

  card_contact_seq #(.STEP_CYC(STEP), .RST_HOLD(HOLD), .DEB_CYC(DEB), .SLOT(4'd1)) u_card_contact_seq (
    .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_off_req(pwr_off_req), .vsel(vsel),
    .card_in(card_in), .vcc_ok(vcc_ok), .fault(fault), .vcc_en(vcc_en), .vcc_cls(vcc_cls),
    .io_en(io_en), .clk_en(clk_en), .rst_out(rst_out), .active(active), .busy(busy),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_param(evt_param));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic win(input int n, input logic [3:0] exp, input string tag);
    int bad = 0;
    logic [3:0] got = exp;
    for (int k = 0; k < n; k++) begin
      if (pins !== exp) begin
        if (bad == 0) got = pins;
        bad++;
      end
      @(negedge clk);
    end
    chk(bad == 0, tag, got, exp);
  endtask

  task automatic pulse_up();
    pwr_up_req = 1; @(negedge clk); pwr_up_req = 0;
  endtask

  task automatic pulse_off();
    pwr_off_req = 1; @(negedge clk); pwr_off_req = 0;
  endtask

  task automatic t_reset();
    chk({pins, active, busy, evt_valid} == 7'b0, "R11 reset state", {pins, active, busy, evt_valid}, 0);
  endtask

  task automatic t_insert();
    int seen = 0;
    card_in = 1;
    for (int k = 1; k <= DEB + 4; k++) begin
      @(negedge clk);
      if (evt_valid && seen == 0) begin
        seen = k;
        chk(evt_code == 8'hC0, "R8 insertion code", evt_code, 8'hC0);
        chk(evt_param == 8'h10, "R8 slot in param", evt_param, 8'h10);
      end
    end
    chk(seen == DEB + 1, "R8 insertion timing", seen, DEB + 1);
  endtask

  task automatic t_glitch();
    int evs = 0;
    card_in = 0;
    repeat (DEB - 2) @(negedge clk);
    card_in = 1;
    for (int k = 0; k < 2 * DEB; k++) begin
      @(negedge clk);
      if (evt_valid) evs++;
    end
    chk(evs == 0, "R8 short glitch ignored", evs, 0);
  endtask

  task automatic t_cold(input logic [1:0] cls);
    vsel = cls;
    pulse_up();
    win(STEP, 4'b1000, "R1 supply step");
    win(STEP, 4'b1100, "R1 io step");
    win(HOLD, 4'b1110, "R1 clock with reset low");
    chk(pins == 4'b1111 && active, "R1 card running", {pins, active}, 5'b11111);
    chk(vcc_cls == cls, "R2 class captured", vcc_cls, cls);
  endtask

  task automatic t_warm();
    vsel = 2'b00;
    pulse_up();
    chk(busy, "R3 busy in warm reset", busy, 1);
    win(HOLD, 4'b1110, "R3 warm reset hold");
    chk(pins == 4'b1111, "R3 released after warm", pins, 4'b1111);
    chk(vcc_cls == 2'b01, "R2 class held over warm reset", vcc_cls, 2'b01);
  endtask

  task automatic t_off();
    pulse_off();
    win(STEP, 4'b1110, "R4 reset drop");
    win(STEP, 4'b1100, "R4 clock stop");
    win(STEP, 4'b1000, "R4 io off");
    chk(pins == 4'b0000 && !busy, "R4 supply off", pins, 0);
  endtask

  task automatic t_vsel3();
    vsel = 2'b11;
    pulse_up();
    repeat (3) @(negedge clk);
    chk(pins == 4'b0000 && !evt_valid, "R2 code 11 ignored", {pins, evt_valid}, 0);
    pulse_off();
    chk(pins == 4'b0000, "R10 off request while off", pins, 0);
  endtask

  task automatic t_ignore();
    vsel = 2'b10;
    pulse_up();
    win(STEP, 4'b1000, "R10 supply step");
    pwr_off_req = 1; pwr_up_req = 1;
    win(STEP, 4'b1100, "R10 io step with requests");
    win(HOLD - 2, 4'b1110, "R10 hold with requests");
    pwr_off_req = 0; pwr_up_req = 0;
    win(2, 4'b1110, "R10 hold tail");
    chk(pins == 4'b1111, "R10 reached running", pins, 4'b1111);
    chk(vcc_cls == 2'b10, "R2 class 1.8V", vcc_cls, 2'b10);
  endtask

  task automatic t_fault_on();
    fault = 1; @(negedge clk); fault = 0;
    chk(evt_valid && evt_code == 8'h40, "R5 deactivated event", evt_code, 8'h40);
    win(STEP, 4'b1110, "R5 reset drop");
    win(STEP, 4'b1100, "R5 clock stop");
    win(STEP, 4'b1000, "R5 io off");
    chk(pins == 4'b0000, "R5 off", pins, 0);
  endtask

  task automatic t_fault_early();
    vsel = 2'b00;
    pulse_up();
    win(STEP, 4'b1000, "R5 supply step");
    win(3, 4'b1100, "R5 io step part");
    fault = 1; @(negedge clk); fault = 0;
    chk(evt_valid && evt_code == 8'h40, "R5 event from io step", evt_code, 8'h40);
    win(STEP, 4'b1100, "R5 clock never started");
    win(STEP, 4'b1000, "R5 io off");
    chk(pins == 4'b0000, "R5 off after early fault", pins, 0);
  endtask

  task automatic t_vccok();
    vcc_ok = 0;
    vsel = 2'b01;
    pulse_up();
    win(STEP, 4'b1000, "R6 supply step");
    chk(evt_valid && evt_code == 8'h40, "R6 supply-good event", evt_code, 8'h40);
    win(STEP, 4'b1000, "R6 io never enabled");
    chk(pins == 4'b0000, "R6 off", pins, 0);
    vcc_ok = 1;
  endtask

  task automatic t_removal();
    t_cold(2'b00);
    card_in = 0;
    win(DEB, 4'b1111, "R9 running during debounce");
    chk(pins == 4'b1110 && !evt_valid, "R9 removal starts deactivation", {pins, evt_valid}, 5'b11100);
    @(negedge clk);
    chk(evt_valid && evt_code == 8'hA0, "R8 extraction code", evt_code, 8'hA0);
    win(STEP - 1, 4'b1110, "R9 reset drop");
    win(STEP, 4'b1100, "R9 clock stop");
    win(STEP, 4'b1000, "R9 io off");
    chk(pins == 4'b0000, "R9 off", pins, 0);
  endtask

  task automatic t_absent();
    vsel = 2'b00;
    pulse_up();
    chk(evt_valid && evt_code == 8'h82, "R7 card absent code", evt_code, 8'h82);
    chk(pins == 4'b0000, "R7 contacts stay off", pins, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_insert();
    t_glitch();
    t_cold(2'b01);
    t_warm();
    t_off();
    t_vsel3();
    t_ignore();
    t_fault_on();
    t_fault_early();
    t_vccok();
    t_removal();
    t_absent();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule